// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator-style 8-bit processor. Each request carries an operation code, the working register W, a file-register operand, an 8-bit literal, the current carry, a destination bit and a bit index. One cycle later the block presents the result, where the result should be written, and new values for the zero (Z), half-carry (DC) and carry (C) flags. Each flag comes with its own write enable. Each operation touches only its own subset of the flags, and the sequencer commits only the flags whose enables are set.

Requests enter on a valid/ready channel and results leave on a valid/ready channel, with one output register between them. A request is taken in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle, so a sink holding `out_ready` high sustains one operation per clock. While `out_valid` is high and `out_ready` is low, every output field stays frozen and no new request is taken. The `out_zero` output reports whether the result is zero, whatever the operation, so that skip logic outside the block can use it.

Operations on the register operand take the file register as their operand; the others take the literal. Subtraction adds the two's complement of W, and C=1 means that no borrow occurred. Fetch, decode, the skip decision and the register file are outside this block.

Top module: `acc_alu`

## Requirements
- R1: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. The result of an accepted request appears with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, all outputs hold their values. After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Addition (register form F+W, literal form K+W) gives the sum modulo 256. C is the carry out of bit 7 and DC is the carry out of bit 3. Z, DC and C are all enabled.
- R3: Subtraction (register form F−W, literal form K−W) is computed as operand + ~W + 1. C=1 when operand ≥ W (no borrow). DC=1 when the operand's low nibble ≥ W's low nibble. Z, DC and C are all enabled.
- R4: AND, inclusive OR and XOR (register form with F, literal form with K), complement of F and move of F all enable only Z.
- R5: Increment and decrement of F give F±1 modulo 256 and enable only Z.
- R6: Clear-file and clear-W give result 0 with Z=1 and enable only Z. Clear-file writes to the file register and clear-W writes to W.
- R7: Rotate-through-carry gives {F[6:0], carry-in} with C = F[7], and enables only C.
- R8: Swap exchanges F[7:4] with F[3:0] and enables no flag.
- R9: Bit-set and bit-clear force bit `in_bit` of F to 1 or 0 and keep every other bit. They enable no flag and write to the file register.
- R10: Register-form operations route the result to W when `in_dest`=0 and to the file register when `in_dest`=1 (`out_dest` follows the same encoding). Literal-form operations always route to W, and move-literal passes K to W with no flag enabled.
- R11: Increment-with-skip and decrement-with-skip produce the same result as increment and decrement but enable no flag. `out_zero` tells the sequencer whether that result is zero.
- R12: `out_zero` equals (result == 0) for every operation. Each flag value output reads 0 whenever its write enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 5 | Operation code (package enumeration) |
| in_w | input | 8 | W register value |
| in_f | input | 8 | File register operand |
| in_k | input | 8 | Literal operand |
| in_cin | input | 1 | Current carry flag |
| in_dest | input | 1 | Destination for register forms: 0 = W, 1 = file |
| in_bit | input | 3 | Bit index for bit-set and bit-clear |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_res | output | 8 | Result value |
| out_dest | output | 1 | Result destination: 0 = W, 1 = file |
| out_z | output | 1 | New Z value |
| out_dc | output | 1 | New DC value |
| out_c | output | 1 | New C value |
| out_we_z | output | 1 | Commit Z |
| out_we_dc | output | 1 | Commit DC |
| out_we_c | output | 1 | Commit C |
| out_zero | output | 1 | Result is zero |

## Verification
The bench builds the block with its default data width of 8 bits. At that width the carry and half-carry boundaries (0xFF+0x01, 0x0F+0x01, equal and unequal nibbles in subtraction) and both end bits of the rotate and of the bit operations can be driven directly. A directed pass covers these corners for every operation. A randomized pass then mixes all operations while the output side stalls in an irregular pattern, which exercises the hold-under-back-pressure and the one-per-cycle acceptance rules.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_REG, OP_ADD_LIT, OP_SUB_REG, OP_SUB_LIT,
    OP_AND_REG, OP_AND_LIT, OP_IOR_REG, OP_IOR_LIT,
    OP_XOR_REG, OP_XOR_LIT, OP_NOT_REG, OP_INC_REG,
    OP_DEC_REG, OP_INC_SKP, OP_DEC_SKP, OP_MOV_REG,
    OP_MOV_LIT, OP_CLR_REG, OP_CLR_W,   OP_ROT_REG,
    OP_SWP_REG, OP_BSET,    OP_BCLR
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } flag_t;

  typedef enum logic [1:0] {
    DST_FOLLOW,
    DST_W,
    DST_FILE
  } dst_mode_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] w,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          dc_out
);
  localparam int NW = DW / 2;

  logic [DW-1:0] b;
  logic [DW:0]   full;
  logic [NW:0]   low;

  always_comb begin
    b      = sub ? ~w : w;
    full   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, sub};
    low    = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, sub};
    sum    = full[DW-1:0];
    c_out  = full[DW];
    dc_out = low[NW];
  end
endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
  import acc_alu_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] f,
  input  logic [DW-1:0] w,
  input  logic [DW-1:0] k,
  input  logic          cin,
  input  logic [BW-1:0] bit_sel,
  output logic [DW-1:0] res
);
  localparam int NW = DW / 2;

  logic [DW-1:0] set_v, clr_v, swp_v, rot_v;

  for (genvar i = 0; i < DW; i++) begin : g_bitop
    assign set_v[i] = (bit_sel == BW'(i)) ? 1'b1 : f[i];
    assign clr_v[i] = (bit_sel == BW'(i)) ? 1'b0 : f[i];
  end

  assign swp_v = {f[NW-1:0], f[DW-1:NW]};
  assign rot_v = {f[DW-2:0], cin};

  always_comb begin
    unique case (op)
      OP_AND_REG:             res = f & w;
      OP_AND_LIT:             res = k & w;
      OP_IOR_REG:             res = f | w;
      OP_IOR_LIT:             res = k | w;
      OP_XOR_REG:             res = f ^ w;
      OP_XOR_LIT:             res = k ^ w;
      OP_NOT_REG:             res = ~f;
      OP_INC_REG, OP_INC_SKP: res = f + DW'(1);
      OP_DEC_REG, OP_DEC_SKP: res = f - DW'(1);
      OP_MOV_LIT:             res = k;
      OP_CLR_REG, OP_CLR_W:   res = '0;
      OP_ROT_REG:             res = rot_v;
      OP_SWP_REG:             res = swp_v;
      OP_BSET:                res = set_v;
      OP_BCLR:                res = clr_v;
      default:                res = f;
    endcase
  end
endmodule

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  alu_op_e   op,
  output flag_t     we,
  output dst_mode_e dst,
  output logic      use_adder,
  output logic      sub,
  output logic      lit,
  output logic      rot
);
  always_comb begin
    we        = '0;
    dst       = DST_FOLLOW;
    use_adder = 1'b0;
    sub       = 1'b0;
    lit       = 1'b0;
    rot       = 1'b0;
    unique case (op)
      OP_ADD_REG: begin use_adder = 1'b1; we = '{1'b1, 1'b1, 1'b1}; end
      OP_ADD_LIT: begin use_adder = 1'b1; lit = 1'b1; dst = DST_W;
                        we = '{1'b1, 1'b1, 1'b1}; end
      OP_SUB_REG: begin use_adder = 1'b1; sub = 1'b1; we = '{1'b1, 1'b1, 1'b1}; end
      OP_SUB_LIT: begin use_adder = 1'b1; sub = 1'b1; lit = 1'b1; dst = DST_W;
                        we = '{1'b1, 1'b1, 1'b1}; end
      OP_AND_REG, OP_IOR_REG, OP_XOR_REG, OP_NOT_REG,
      OP_INC_REG, OP_DEC_REG, OP_MOV_REG: we.z = 1'b1;
      OP_AND_LIT, OP_IOR_LIT, OP_XOR_LIT: begin we.z = 1'b1; dst = DST_W; end
      OP_MOV_LIT: dst = DST_W;
      OP_CLR_REG: begin we.z = 1'b1; dst = DST_FILE; end
      OP_CLR_W:   begin we.z = 1'b1; dst = DST_W; end
      OP_ROT_REG: begin we.c = 1'b1; rot = 1'b1; end
      OP_BSET, OP_BCLR: dst = DST_FILE;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [DW-1:0] in_w,
  input  logic [DW-1:0] in_f,
  input  logic [DW-1:0] in_k,
  input  logic          in_cin,
  input  logic          in_dest,
  input  logic [BW-1:0] in_bit,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_res,
  output logic          out_dest,
  output logic          out_z,
  output logic          out_dc,
  output logic          out_c,
  output logic          out_we_z,
  output logic          out_we_dc,
  output logic          out_we_c,
  output logic          out_zero
);
  alu_op_e   op;
  flag_t     we, fv;
  dst_mode_e dst;
  logic      use_adder, sub, lit, rot;
  logic [DW-1:0] opnd, sum, ures, res_n;
  logic      c_add, dc_add, dest_n, take;

  assign op = alu_op_e'(in_op);

  acc_alu_decode u_dec (
    .op(op), .we(we), .dst(dst), .use_adder(use_adder),
    .sub(sub), .lit(lit), .rot(rot)
  );

  assign opnd = lit ? in_k : in_f;

  acc_alu_addsub #(.DW(DW)) u_add (
    .a(opnd), .w(in_w), .sub(sub), .sum(sum), .c_out(c_add), .dc_out(dc_add)
  );

  acc_alu_unary #(.DW(DW)) u_una (
    .op(op), .f(in_f), .w(in_w), .k(in_k), .cin(in_cin),
    .bit_sel(in_bit), .res(ures)
  );

  always_comb begin
    res_n = use_adder ? sum : ures;
    fv.z  = we.z & (res_n == '0);
    fv.dc = we.dc & dc_add;
    fv.c  = we.c & (rot ? in_f[DW-1] : c_add);
    unique case (dst)
      DST_W:    dest_n = 1'b0;
      DST_FILE: dest_n = 1'b1;
      default:  dest_n = in_dest;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_dest  <= 1'b0;
      out_z     <= 1'b0;
      out_dc    <= 1'b0;
      out_c     <= 1'b0;
      out_we_z  <= 1'b0;
      out_we_dc <= 1'b0;
      out_we_c  <= 1'b0;
      out_zero  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_res   <= res_n;
      out_dest  <= dest_n;
      out_z     <= fv.z;
      out_dc    <= fv.dc;
      out_c     <= fv.c;
      out_we_z  <= we.z;
      out_we_dc <= we.dc;
      out_we_c  <= we.c;
      out_zero  <= (res_n == '0);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_res,
  input logic          out_z,
  input logic          out_dc,
  input logic          out_c,
  input logic          out_we_z,
  input logic          out_we_dc,
  input logic          out_we_c,
  input logic          out_zero
);
  p_accept_fills_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_empty_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_stall_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_zero)
      && $stable({out_z, out_dc, out_c, out_we_z, out_we_dc, out_we_c}));

  p_dc_implies_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_we_dc |-> out_we_c && out_we_z);

  p_rot_only_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_we_c && !out_we_dc |-> !out_we_z);

  p_zero_matches_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_we_z |-> out_z == out_zero);

  p_idle_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_z || out_we_z) && (!out_dc || out_we_dc) && (!out_c || out_we_c));
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
  .out_z(out_z), .out_dc(out_dc), .out_c(out_c), .out_we_z(out_we_z),
  .out_we_dc(out_we_dc), .out_we_c(out_we_c), .out_zero(out_zero)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  import acc_alu_pkg::*;

  typedef struct {
    logic [7:0] res;
    logic dest, z, dc, c, wz, wdc, wc, zero;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_w = '0, in_f = '0, in_k = '0;
  logic in_cin = 1'b0, in_dest = 1'b0;
  logic [2:0] in_bit = '0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_res;
  logic out_dest, out_z, out_dc, out_c, out_we_z, out_we_dc, out_we_c, out_zero;

  int checks = 0, failures = 0;
  exp_t q[$];
  bit stall_mode = 1'b0;
  int unsigned rcnt = 0;

  always #10 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_w(in_w), .in_f(in_f), .in_k(in_k), .in_cin(in_cin),
    .in_dest(in_dest), .in_bit(in_bit), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_dest(out_dest),
    .out_z(out_z), .out_dc(out_dc), .out_c(out_c), .out_we_z(out_we_z),
    .out_we_dc(out_we_dc), .out_we_c(out_we_c), .out_zero(out_zero)
  );

  function automatic exp_t model(alu_op_e op, logic [7:0] w, logic [7:0] f,
                                 logic [7:0] k, logic cin, logic dest,
                                 logic [2:0] b, string tag);
    exp_t e;
    int a;
    e = '{res: 8'h00, dest: dest, z: 0, dc: 0, c: 0, wz: 0, wdc: 0, wc: 0,
          zero: 0, tag: tag};
    a = (op == OP_ADD_LIT || op == OP_SUB_LIT) ? int'(k) : int'(f);
    case (op)
      OP_ADD_REG, OP_ADD_LIT: begin
        e.res = 8'((a + int'(w)) % 256);
        e.c = (a + int'(w)) > 255;
        e.dc = ((a % 16) + (int'(w) % 16)) > 15;
        e.wz = 1; e.wdc = 1; e.wc = 1;
      end
      OP_SUB_REG, OP_SUB_LIT: begin
        e.res = 8'((a - int'(w) + 256) % 256);
        e.c = a >= int'(w);
        e.dc = (a % 16) >= (int'(w) % 16);
        e.wz = 1; e.wdc = 1; e.wc = 1;
      end
      OP_AND_REG: begin e.res = f & w; e.wz = 1; end
      OP_AND_LIT: begin e.res = k & w; e.wz = 1; end
      OP_IOR_REG: begin e.res = f | w; e.wz = 1; end
      OP_IOR_LIT: begin e.res = k | w; e.wz = 1; end
      OP_XOR_REG: begin e.res = f ^ w; e.wz = 1; end
      OP_XOR_LIT: begin e.res = k ^ w; e.wz = 1; end
      OP_NOT_REG: begin e.res = 8'(255 - int'(f)); e.wz = 1; end
      OP_INC_REG: begin e.res = 8'((int'(f) + 1) % 256); e.wz = 1; end
      OP_DEC_REG: begin e.res = 8'((int'(f) + 255) % 256); e.wz = 1; end
      OP_INC_SKP: e.res = 8'((int'(f) + 1) % 256);
      OP_DEC_SKP: e.res = 8'((int'(f) + 255) % 256);
      OP_MOV_REG: begin e.res = f; e.wz = 1; end
      OP_MOV_LIT: e.res = k;
      OP_CLR_REG: begin e.res = 0; e.wz = 1; e.dest = 1; end
      OP_CLR_W:   begin e.res = 0; e.wz = 1; e.dest = 0; end
      OP_ROT_REG: begin e.res = 8'((int'(f) * 2 + int'(cin)) % 256); e.c = f[7]; e.wc = 1; end
      OP_SWP_REG: e.res = 8'((int'(f) % 16) * 16 + int'(f) / 16);
      OP_BSET: begin e.res = f; e.res[b] = 1'b1; e.dest = 1; end
      OP_BCLR: begin e.res = f; e.res[b] = 1'b0; e.dest = 1; end
      default: e.res = f;
    endcase
    if (op == OP_ADD_LIT || op == OP_SUB_LIT || op == OP_AND_LIT || op == OP_IOR_LIT ||
        op == OP_XOR_LIT || op == OP_MOV_LIT)
      e.dest = 0;
    e.zero = (e.res == 0);
    if (e.wz) e.z = e.zero;
    return e;
  endfunction

  task automatic send(alu_op_e op, logic [7:0] w, logic [7:0] f, logic [7:0] k,
                      logic cin, logic dest, logic [2:0] b, string tag);
    @(negedge clk);
    in_op = op; in_w = w; in_f = f; in_k = k; in_cin = cin; in_dest = dest; in_bit = b;
    in_valid = 1'b1;
    q.push_back(model(op, w, f, k, cin, dest, b, tag));
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #3;
    rcnt = rcnt + 1;
    out_ready = stall_mode ? ((rcnt % 3 == 0) || (rcnt % 7 == 2)) : 1'b1;
  end

  logic prev_stall = 1'b0;
  logic [7:0] prev_res = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!out_valid || out_res !== prev_res) begin
          failures++;
          $display("FAIL R1 hold under stall: actual valid=%0b res=%02h expected valid=1 res=%02h",
                   out_valid, out_res, prev_res);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_res = out_res;
      if (out_valid && out_ready) begin
        checks++;
        if (q.size() == 0) begin
          failures++;
          $display("FAIL R1 unexpected output: actual res=%02h expected none", out_res);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (out_res !== e.res || out_dest !== e.dest || out_z !== e.z || out_dc !== e.dc ||
              out_c !== e.c || out_we_z !== e.wz || out_we_dc !== e.wdc ||
              out_we_c !== e.wc || out_zero !== e.zero) begin
            failures++;
            $display("FAIL %s: actual res=%02h d=%0b zdc c=%0b%0b%0b we=%0b%0b%0b zero=%0b expected res=%02h d=%0b zdc c=%0b%0b%0b we=%0b%0b%0b zero=%0b",
                     e.tag, out_res, out_dest, out_z, out_dc, out_c, out_we_z, out_we_dc,
                     out_we_c, out_zero, e.res, e.dest, e.z, e.dc, e.c, e.wz, e.wdc,
                     e.wc, e.zero);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset state: actual valid=%0b ready=%0b expected valid=0 ready=1",
               out_valid, in_ready);
    end
    // R2 addition corners
    send(OP_ADD_REG, 8'h01, 8'hFF, 8'h00, 0, 1, 0, "R2 add FF+01");
    send(OP_ADD_REG, 8'h01, 8'h0F, 8'h00, 0, 0, 0, "R2 add 0F+01");
    send(OP_ADD_LIT, 8'h30, 8'h00, 8'h25, 0, 1, 0, "R2 add literal");
    // R3 subtraction corners
    send(OP_SUB_REG, 8'h05, 8'h05, 8'h00, 0, 1, 0, "R3 sub equal");
    send(OP_SUB_REG, 8'h05, 8'h03, 8'h00, 1, 0, 0, "R3 sub borrow");
    send(OP_SUB_LIT, 8'h01, 8'h00, 8'h10, 0, 0, 0, "R3 sub literal nibble borrow");
    // R4 logic
    send(OP_AND_REG, 8'hF0, 8'h0F, 8'h00, 1, 1, 0, "R4 and zero");
    send(OP_IOR_LIT, 8'h50, 8'h00, 8'h0A, 1, 1, 0, "R4 ior literal");
    send(OP_XOR_REG, 8'hAA, 8'hFF, 8'h00, 0, 0, 0, "R4 xor");
    send(OP_NOT_REG, 8'h00, 8'hFF, 8'h00, 1, 1, 0, "R4 complement");
    send(OP_MOV_REG, 8'h11, 8'h00, 8'h00, 0, 0, 0, "R4 move zero");
    // R5 inc/dec wrap
    send(OP_INC_REG, 8'h00, 8'hFF, 8'h00, 1, 1, 0, "R5 inc wrap");
    send(OP_DEC_REG, 8'h00, 8'h00, 8'h00, 1, 0, 0, "R5 dec wrap");
    // R6 clears
    send(OP_CLR_REG, 8'h12, 8'h34, 8'h00, 1, 0, 0, "R6 clear file");
    send(OP_CLR_W,   8'h12, 8'h34, 8'h00, 1, 1, 0, "R6 clear W");
    // R7 rotate
    send(OP_ROT_REG, 8'h00, 8'h80, 8'h00, 1, 1, 0, "R7 rotate cin1");
    send(OP_ROT_REG, 8'h00, 8'h41, 8'h00, 0, 0, 0, "R7 rotate cin0");
    // R8 swap
    send(OP_SWP_REG, 8'h00, 8'hA5, 8'h00, 1, 1, 0, "R8 swap");
    // R9 bit ops
    send(OP_BSET, 8'h00, 8'h00, 8'h00, 0, 0, 3'd7, "R9 set bit7");
    send(OP_BCLR, 8'h00, 8'hFF, 8'h00, 1, 0, 3'd0, "R9 clear bit0");
    // R10 destination and move literal
    send(OP_XOR_LIT, 8'h0F, 8'h00, 8'hF0, 0, 1, 0, "R10 literal to W");
    send(OP_MOV_LIT, 8'h00, 8'h00, 8'h5C, 1, 1, 0, "R10 move literal");
    // R11 skip forms
    send(OP_INC_SKP, 8'h00, 8'hFF, 8'h00, 0, 1, 0, "R11 inc skip zero");
    send(OP_DEC_SKP, 8'h00, 8'h02, 8'h00, 0, 0, 0, "R11 dec skip nonzero");
    // R1 R12 random mix under back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send(alu_op_e'($urandom_range(0, 22)), 8'($urandom), 8'($urandom), 8'($urandom),
           1'($urandom), 1'($urandom), 3'($urandom), "R12 random stalled");
    end
    stall_mode = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule